// File: doc/BRIEF.md
# Multi-format Audio Serial Transmitter

This block turns a set of parallel audio samples into one serial data stream that follows an externally supplied bit clock and frame clock. The bit clock and frame clock are oversampled in the block's own system clock domain. The block finds their edges there, tracks its position inside the current frame, and updates the serial output once for each falling bit-clock edge. The same logic serves four framings: two channels with a one-bit data delay, two channels with the data aligned to the frame edge, a four-slot multiplexed frame of 128 bit clocks, and an eight-slot multiplexed frame of 256 bit clocks.

A frame starts when the sampled frame clock reaches its start level. At that moment the sample inputs are copied into a holding register, and a one-cycle strobe tells the upstream source that it may present the next set. Each slot is 32 bit clocks long and carries a 24-bit two's-complement sample, MSB first, followed by zero padding. Slots at or above the programmed channel count send zeros. The block also watches the frame clock and flags a phase that ends before any rising bit-clock edge has occurred. While power-down is asserted the output stays low and all frame tracking is cleared.

Top module: `aud_tdm_tx`

## Requirements
- R1: Each slot is 32 bit clocks wide. The sample's bit 23 is sent in the slot's first bit clock and its bit 0 in the 24th. The remaining 8 bit clocks of the slot send 0.
- R2: `sdto` changes only in the system clock cycle that follows a detected falling edge of `sclk` (`sclk` high in the previous cycle and low now). It holds its value across rising `sclk` edges.
- R3: Frame length depends on `fmt`: 64 bit clocks for codes 0 and 1, 128 for code 2 (four slots) and 256 for code 3 (eight slots). Slot k covers frame positions 32k to 32k+31. Once a frame has run its full length and no new frame has started, `sdto` is 0.
- R4: With `fmt` = 1 (edge-aligned) or 2 or 3 (multiplexed), a frame starts when `lrck` is sampled high on a rising `sclk` edge after having been sampled low on the previous one. The first bit of slot 0 is sent on the next falling `sclk` edge.
- R5: With `fmt` = 0 (delayed framing), a frame starts when `lrck` is sampled low after having been sampled high. Position 0 sends 0, and every slot bit is sent one bit clock later than in R4.
- R6: Slots whose index is at or above `num_ch` send 0 for all 32 of their bit clocks.
- R7: The samples are taken from `samples` only at frame start (slot k is `samples[24k+23:24k]`). Changes to `samples` later in the frame do not affect the frame being sent.
- R8: `consumed` is high for exactly one system clock cycle at each frame start.
- R9: While `pwr_dn` is high, `sdto` is 0, `consumed` stays low and no frame starts.
- R10: `lrck_err` pulses high for one cycle when `lrck` changes twice with no rising `sclk` edge between the two changes. It does not pulse on the first change after reset or power-down.
- R11: After reset, `sdto`, `consumed` and `lrck_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than `sclk` |
| rst | input | 1 | Synchronous active-high reset |
| pwr_dn | input | 1 | Power-down: holds the output low and clears frame state |
| fmt | input | 2 | Framing: 0 delayed two-channel, 1 edge-aligned two-channel, 2 four-slot, 3 eight-slot |
| num_ch | input | 4 | Number of slots that carry sample data |
| sclk | input | 1 | Bit clock |
| lrck | input | 1 | Frame clock |
| samples | input | 192 | Eight 24-bit samples; slot k in bits 24k+23 down to 24k |
| sdto | output | 1 | Serial data out |
| consumed | output | 1 | One-cycle strobe when a sample set is latched |
| lrck_err | output | 1 | One-cycle flag for a frame clock phase that is too short |

## Verification
The bench runs every framing with corner sample values (most negative, most positive, all ones, LSB only) and with random sample sets. In each run it changes the inputs halfway through every frame. A design that latches samples continuously would send a mix of two sets, and an off-by-one in the delayed framing would shift every bit and break the checks on padding and on the first position. Partial channel counts in the multiplexed frames catch a design that sends stale data in unused slots. The bench also checks that the output is zero after the last frame, which catches a counter that wraps instead of stopping. Directed tests drive a double frame-clock toggle with no bit clock in between, and run full bit-clock activity under power-down. A design that missed the violation, or that leaked data or strobes during power-down, fails these counts.

// File: rtl/aud_tx_pkg.sv
package aud_tx_pkg;

    parameter int SLOT_W    = 32;
    parameter int SAMPLE_W  = 24;
    parameter int MAX_SLOTS = 8;

    localparam int SLOT_SH    = $clog2(SLOT_W);
    localparam int SLOT_IDX_W = $clog2(MAX_SLOTS);
    localparam int POS_W      = SLOT_SH + SLOT_IDX_W;
    localparam int CH_W       = SLOT_IDX_W + 1;
    localparam int FLAT_W     = MAX_SLOTS * SAMPLE_W;

    typedef enum logic [1:0] {
        FMT_DLY  = 2'd0,
        FMT_EDGE = 2'd1,
        FMT_TDM4 = 2'd2,
        FMT_TDM8 = 2'd3
    } fmt_e;

    typedef logic [SAMPLE_W-1:0]            sample_t;
    typedef sample_t [MAX_SLOTS-1:0]        sample_set_t;

    typedef struct packed {
        logic             active;
        logic [POS_W-1:0] pos;
    } frame_pos_t;

    function automatic logic [POS_W-1:0] last_pos(input fmt_e f);
        case (f)
            FMT_TDM4: return POS_W'(4 * SLOT_W - 1);
            FMT_TDM8: return POS_W'(8 * SLOT_W - 1);
            default:  return POS_W'(2 * SLOT_W - 1);
        endcase
    endfunction

    function automatic logic start_level(input fmt_e f);
        return (f != FMT_DLY);
    endfunction

    function automatic logic serial_bit(input sample_set_t set,
                                        input fmt_e        f,
                                        input logic [CH_W-1:0] nch,
                                        input logic [POS_W-1:0] pos);
        logic [POS_W-1:0]      idx;
        logic [SLOT_IDX_W-1:0] slot;
        logic [SLOT_SH-1:0]    bitn;
        localparam logic [SLOT_SH-1:0] SAMPLE_LAST = SLOT_SH'(SAMPLE_W - 1);
        if (f == FMT_DLY) begin
            if (pos == '0) return 1'b0;
            idx = pos - POS_W'(1);
        end else begin
            idx = pos;
        end
        slot = idx[POS_W-1:SLOT_SH];
        bitn = idx[SLOT_SH-1:0];
        if ({1'b0, slot} >= nch) return 1'b0;
        if (bitn > SAMPLE_LAST)  return 1'b0;
        return set[slot][SAMPLE_LAST - bitn];
    endfunction

endpackage

// File: rtl/aud_tx_edges.sv
module aud_tx_edges
    import aud_tx_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic pwr_dn,
    input  logic sclk,
    input  logic lrck,
    input  logic start_lvl,
    output logic sclk_fall,
    output logic start_pend,
    output logic lrck_err
);
    logic sclk_d, lrck_d, lr_seen, rise_seen, armed;
    logic sclk_rise, lr_chg;

    assign sclk_rise = sclk & ~sclk_d;
    assign sclk_fall = ~sclk & sclk_d;
    assign lr_chg    = lrck ^ lrck_d;

    always_ff @(posedge clk) begin
        if (rst || pwr_dn) begin
            sclk_d     <= sclk;
            lrck_d     <= lrck;
            lr_seen    <= 1'b0;
            rise_seen  <= 1'b0;
            armed      <= 1'b0;
            start_pend <= 1'b0;
            lrck_err   <= 1'b0;
        end else begin
            sclk_d   <= sclk;
            lrck_d   <= lrck;
            lrck_err <= lr_chg & armed & ~rise_seen;
            if (lr_chg) begin
                armed     <= 1'b1;
                rise_seen <= sclk_rise;
            end else if (sclk_rise) begin
                rise_seen <= 1'b1;
            end
            if (sclk_rise) begin
                lr_seen <= lrck;
                if (lrck != lr_seen && lrck == start_lvl)
                    start_pend <= 1'b1;
            end else if (sclk_fall) begin
                start_pend <= 1'b0;
            end
        end
    end

    AST_ERR_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
        lrck_err |-> ($past(lrck) != $past(lrck, 2))); // R10

    AST_NO_PEND_IN_PD: assert property (@(posedge clk) disable iff (rst)
        pwr_dn |=> !start_pend); // R9

endmodule

// File: rtl/aud_tx_framer.sv
module aud_tx_framer
    import aud_tx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             pwr_dn,
    input  logic             sclk_fall,
    input  logic             start_pend,
    input  logic [POS_W-1:0] frame_last,
    output logic             start,
    output frame_pos_t       cur,
    output frame_pos_t       nxt
);
    assign start = sclk_fall & start_pend;

    always_comb begin
        nxt = cur;
        if (start) begin
            nxt.active = 1'b1;
            nxt.pos    = '0;
        end else if (sclk_fall && cur.active) begin
            if (cur.pos == frame_last) begin
                nxt.active = 1'b0;
                nxt.pos    = '0;
            end else begin
                nxt.pos = cur.pos + POS_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || pwr_dn) cur <= '0;
        else               cur <= nxt;
    end

    AST_HOLD_NO_FALL: assert property (@(posedge clk) disable iff (rst)
        (!sclk_fall && !pwr_dn) |=> $stable(cur)); // R2

    AST_START_POS0: assert property (@(posedge clk) disable iff (rst)
        (start && !pwr_dn) |=> (cur.active && cur.pos == '0)); // R4

endmodule

// File: rtl/aud_tx_slotsel.sv
module aud_tx_slotsel
    import aud_tx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  sample_set_t      samples_in,
    input  fmt_e             fmt,
    input  logic [CH_W-1:0]  nch,
    input  frame_pos_t       at,
    output logic             bit_out
);
    sample_set_t hold;
    sample_set_t src;

    always_ff @(posedge clk) begin
        if (rst)       hold <= '0;
        else if (load) hold <= samples_in;
    end

    assign src     = load ? samples_in : hold;
    assign bit_out = at.active ? serial_bit(src, fmt, nch, at.pos) : 1'b0;

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(hold)); // R7

endmodule

// File: rtl/aud_tdm_tx.sv
module aud_tdm_tx
    import aud_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              pwr_dn,
    input  logic [1:0]        fmt,
    input  logic [CH_W-1:0]   num_ch,
    input  logic              sclk,
    input  logic              lrck,
    input  logic [FLAT_W-1:0] samples,
    output logic              sdto,
    output logic              consumed,
    output logic              lrck_err
);
    fmt_e        fmt_sel;
    sample_set_t set_in;
    logic        sclk_fall, start_pend, start, bit_now;
    frame_pos_t  pos_cur, pos_nxt;

    assign fmt_sel = fmt_e'(fmt);
    assign set_in  = sample_set_t'(samples);

    aud_tx_edges u_edges (
        .clk        (clk),
        .rst        (rst),
        .pwr_dn     (pwr_dn),
        .sclk       (sclk),
        .lrck       (lrck),
        .start_lvl  (start_level(fmt_sel)),
        .sclk_fall  (sclk_fall),
        .start_pend (start_pend),
        .lrck_err   (lrck_err)
    );

    aud_tx_framer u_framer (
        .clk        (clk),
        .rst        (rst),
        .pwr_dn     (pwr_dn),
        .sclk_fall  (sclk_fall),
        .start_pend (start_pend),
        .frame_last (last_pos(fmt_sel)),
        .start      (start),
        .cur        (pos_cur),
        .nxt        (pos_nxt)
    );

    aud_tx_slotsel u_slotsel (
        .clk        (clk),
        .rst        (rst),
        .load       (start & ~pwr_dn),
        .samples_in (set_in),
        .fmt        (fmt_sel),
        .nch        (num_ch),
        .at         (pos_nxt),
        .bit_out    (bit_now)
    );

    always_ff @(posedge clk) begin
        if (rst || pwr_dn) begin
            sdto     <= 1'b0;
            consumed <= 1'b0;
        end else begin
            consumed <= start;
            if (sclk_fall) sdto <= bit_now;
        end
    end

    AST_PD_LOW: assert property (@(posedge clk) disable iff (rst)
        pwr_dn |=> !sdto); // R9

    AST_PD_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
        pwr_dn |=> !consumed); // R9

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        consumed |=> !consumed); // R8

    AST_SDTO_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        (!sclk_fall && !pwr_dn) |=> $stable(sdto)); // R2

endmodule

// File: tb/aud_tdm_tx_bench.sv
module aud_tdm_tx_bench;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int HALF = 4;
    localparam int SW   = 24;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         pwr_dn = 1'b0;
    logic [1:0]   fmt = 2'd1;
    logic [3:0]   num_ch = 4'd2;
    logic         sclk = 1'b1;
    logic         lrck = 1'b0;
    logic [191:0] samples = '0;
    logic         sdto, consumed, lrck_err;

    logic [SW-1:0] drive_set [8];
    logic [SW-1:0] exp_set   [8];

    int errors = 0;
    int checks = 0;
    int cons_cnt = 0;
    int err_cnt  = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    aud_tdm_tx u_aud_tdm_tx (
        .clk(clk), .rst(rst), .pwr_dn(pwr_dn), .fmt(fmt), .num_ch(num_ch),
        .sclk(sclk), .lrck(lrck), .samples(samples),
        .sdto(sdto), .consumed(consumed), .lrck_err(lrck_err)
    );

    always @(posedge clk) begin
        if (consumed) cons_cnt <= cons_cnt + 1;
        if (lrck_err) err_cnt  <= err_cnt + 1;
    end

    task automatic check(input string req, input logic got, input logic want);
        checks++;
        if (got !== want) begin
            errors++;
            $display("FAIL %s: got %0b expected %0b at %0t", req, got, want, $time);
        end
    endtask

    task automatic check_int(input string req, input int got, input int want);
        checks++;
        if (got != want) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, got, want);
        end
    endtask

    task automatic apply_set();
        for (int k = 0; k < 8; k++) samples[k*SW +: SW] = drive_set[k];
    endtask

    function automatic int flen(input int f);
        return (f == 2) ? 128 : (f == 3) ? 256 : 64;
    endfunction

    function automatic logic pat(input int f, input int q);
        if (f == 0) return (q >= 32);
        if (f == 1) return (q < 32);
        return (q < 8);
    endfunction

    function automatic logic exp_bit(input int f, input int nch, input int p);
        int idx, slot, b;
        logic [31:0] word;
        idx = p;
        if (f == 0) begin
            if (p == 0) return 1'b0;
            idx = p - 1;
        end
        slot = idx / 32;
        b    = idx % 32;
        if (slot >= nch) return 1'b0;
        word = {exp_set[slot], 8'h00};
        return word[31 - b];
    endfunction

    function automatic string tag_for(input int f, input int nch, input int p);
        int idx;
        idx = (f == 0) ? p - 1 : p;
        if (f == 0 && p <= 1) return "R5";
        if (f != 0 && p == 0) return "R4";
        if (idx / 32 >= nch)  return "R6";
        if (idx >= 64)        return "R3";
        return "R1";
    endfunction

    // One bit clock: fall with new lrck, check before and after the rise
    task automatic bitclk(input logic lr, input logic expv, input string req);
        @(negedge clk);
        sclk = 1'b0;
        lrck = lr;
        repeat (HALF) @(negedge clk);
        check(req, sdto, expv);
        sclk = 1'b1;
        repeat (HALF) @(negedge clk);
        check("R2", sdto, expv);
    endtask

    task automatic rand_set();
        for (int k = 0; k < 8; k++) drive_set[k] = SW'($urandom);
        apply_set();
    endtask

    task automatic run_fmt(input int f, input int nch, input int frames);
        int fb, c0, e0;
        logic lr;
        fb = flen(f);
        @(negedge clk);
        pwr_dn = 1'b1;
        fmt    = 2'(f);
        num_ch = 4'(nch);
        repeat (3) @(negedge clk);
        pwr_dn = 1'b0;
        c0 = cons_cnt;
        e0 = err_cnt;
        drive_set[0] = 24'h800000; drive_set[1] = 24'h7FFFFF;
        drive_set[2] = 24'hFFFFFF; drive_set[3] = 24'h000001;
        drive_set[4] = 24'hA5A5A5; drive_set[5] = 24'h5A5A5A;
        drive_set[6] = 24'h123456; drive_set[7] = 24'hFEDCBA;
        apply_set();
        bitclk(pat(f, fb - 1), 1'b0, "R3");
        bitclk(pat(f, fb - 1), 1'b0, "R3");
        bitclk(pat(f, 0), 1'b0, "R3");
        for (int fr = 0; fr < frames; fr++) begin
            for (int p = 0; p < fb; p++) begin
                if (p == 0)
                    for (int k = 0; k < 8; k++) exp_set[k] = drive_set[k];
                lr = (fr == frames - 1 && p == fb - 1) ? pat(f, fb - 1)
                                                       : pat(f, (p + 1) % fb);
                bitclk(lr, exp_bit(f, nch, p), tag_for(f, nch, p));
                if (p == fb / 2) rand_set(); // R7: mid-frame change
            end
        end
        bitclk(pat(f, fb - 1), 1'b0, "R3");
        bitclk(pat(f, fb - 1), 1'b0, "R3");
        @(negedge clk);
        check_int("R8 strobe count", cons_cnt - c0, frames);
        check_int("R10 no false flag", err_cnt - e0, 0);
    endtask

    initial begin
        void'($urandom(32'h5EED_0A11));
        for (int k = 0; k < 8; k++) drive_set[k] = '0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R11 sdto", sdto, 1'b0);
        check("R11 consumed", consumed, 1'b0);
        check("R11 lrck_err", lrck_err, 1'b0);

        run_fmt(1, 2, 3);
        run_fmt(0, 2, 3);
        run_fmt(2, 3, 2);
        run_fmt(2, 4, 1);
        run_fmt(3, 8, 2);
        run_fmt(3, 5, 1);
        run_fmt(0, 1, 1);

        // R9: full activity under power-down
        begin
            int c0;
            @(negedge clk);
            pwr_dn = 1'b1;
            fmt = 2'd1;
            num_ch = 4'd2;
            for (int k = 0; k < 8; k++) drive_set[k] = 24'hFFFFFF;
            apply_set();
            c0 = cons_cnt;
            for (int p = 0; p < 70; p++) bitclk(pat(1, (p + 1) % 64), 1'b0, "R9");
            check_int("R9 strobe", cons_cnt - c0, 0);
            pwr_dn = 1'b0;
        end

        // R10: two lrck changes without a rising sclk
        begin
            int e0;
            @(negedge clk);
            pwr_dn = 1'b1;
            repeat (2) @(negedge clk);
            pwr_dn = 1'b0;
            e0 = err_cnt;
            repeat (2) @(negedge clk);
            lrck = ~lrck;
            repeat (3) @(negedge clk);
            check_int("R10 first change", err_cnt - e0, 0);
            lrck = ~lrck;
            repeat (3) @(negedge clk);
            check_int("R10 violation", err_cnt - e0, 1);
            check("R10 pulse ends", lrck_err, 1'b0);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule